// File: doc/BRIEF.md
# Lockstep Duplex Comparator with Self-Checking Error Path

This block sits between two identical processors that run the same program in lockstep. Every cycle in which either processor asserts its bus-valid strobe, it compares the two output buses: address, write data, control strobes and the valid strobe itself. One processor's lanes are inverted before they enter the comparison. A match therefore gives a complementary pair on every lane. A tree of two-rail checker cells folds these pairs into one registered two-rail result. A complementary result (10 or 01) means agreement. A non-complementary result (00 or 11) means either a processor mismatch or a fault inside the tree itself. In both cases the fault reaches the output as an invalid code instead of being masked.

A small state machine watches the registered result. It has three states:
- **ST_RUN**: normal operation.
- **ST_ALERT**: a one-cycle state that raises the error pulse to the memory system and starts the halt.
- **ST_HALTED**: the pair is held stopped.

Transitions:
- **ST_RUN → ST_ALERT**: taken on an invalid code.
- **ST_ALERT → ST_HALTED**: always taken.
- **ST_HALTED → ST_RUN**: taken on the recovery-done input.

The invalid code that caused the halt is latched for the recovery logic. A test input flips one chosen lane of the second processor's bus, so the whole error path can be exercised on a healthy pair.

Top module: `lockstep_duplex_cmp`

## Requirements
- R1: After reset, `halt_req` and `err_to_mem` are 0, and both `chk_rail` and `first_code` read 2'b01.
- R2: If the lanes agree in a compared cycle that is not halted, `chk_rail` after the next clock edge reads 2'b10 when the first processor's 37-bit lane vector holds an even number of zero bits, and 2'b01 when it holds an odd number. The lane vector is {valid, ctrl[3:0], wdata[15:0], addr[15:0]}, with addr in bits 15:0, wdata in bits 31:16, ctrl in bits 35:32 and valid in bit 36.
- R3: In a compared cycle that is not halted and where the lanes differ, `chk_rail` after the next edge reads 2'b00 if any differing lane has a 0 on the first processor's side. Otherwise it reads 2'b11.
- R4: A cycle in which neither `a_valid` nor `b_valid` is high is not compared, and `chk_rail` after the next edge reads 2'b01 whatever the buses carry.
- R5: When `chk_rail` holds 00 or 11 while `halt_req` is low (ST_RUN), `err_to_mem` and `halt_req` are both high in the following cycle (ST_ALERT).
- R6: `err_to_mem` is high for exactly one cycle per detected error. `halt_req` stays high through ST_ALERT and ST_HALTED until `recover_done` is sampled high in ST_HALTED. `recover_done` has no effect in ST_RUN or ST_ALERT.
- R7: `first_code` captures the invalid `chk_rail` code that caused entry to ST_ALERT. Later mismatches do not change it while the halt is held. It returns to 2'b01 when the halt clears.
- R8: While `halt_req` is high, no comparison is taken. This includes the cycle in which `recover_done` releases the halt, and `chk_rail` after that edge reads 2'b01.
- R9: With `inject_en` high, lane `inject_sel` (numbered as in R2) of the second processor's vector is inverted before comparison. A value of `inject_sel` of 37 or more inverts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 16 | Address bus, first processor |
| a_wdata | input | 16 | Write data bus, first processor |
| a_ctrl | input | 4 | Control strobes, first processor |
| a_valid | input | 1 | Bus-valid strobe, first processor |
| b_addr | input | 16 | Address bus, second processor |
| b_wdata | input | 16 | Write data bus, second processor |
| b_ctrl | input | 4 | Control strobes, second processor |
| b_valid | input | 1 | Bus-valid strobe, second processor |
| recover_done | input | 1 | Recovery finished; releases the halt in ST_HALTED |
| inject_en | input | 1 | Test mode: invert one lane of the second processor |
| inject_sel | input | 6 | Lane index to invert |
| chk_rail | output | 2 | Registered two-rail comparison result |
| err_to_mem | output | 1 | One-cycle error indication to the memory system |
| halt_req | output | 1 | Held request to stop both processors |
| first_code | output | 2 | Invalid code latched at the first error |

## Verification
The collision that matters is a new mismatch arriving in the same cycle as `recover_done` in ST_HALTED. The block must take the release and must not compare that cycle, so the pair resumes without a spurious second halt. The bench provokes this directly by driving differing buses together with `recover_done` while halted. It also lets the random phase hit the case with a recovery strobe on one cycle in four. A reference model judges each cycle, gating comparison on its own halt state, and expects 2'b01 on `chk_rail` and ST_RUN afterwards. A second pairing, an ignored `recover_done` in ST_ALERT, is driven deliberately in the same way.

// File: rtl/duplex_pkg.sv
package duplex_pkg;

    // Halt controller states
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ALERT  = 2'd1,
        ST_HALTED = 2'd2
    } dx_state_e;

    // Code reported when no comparison is taken
    localparam logic [1:0] RAIL_IDLE = 2'b01;

    // A two-rail pair is valid only when its rails differ
    function automatic logic rail_invalid(input logic [1:0] r);
        return (r[1] == r[0]);
    endfunction

endpackage

// File: rtl/duplex_rail_cell.sv
// One two-rail checker cell: output is complementary only if both
// input pairs are complementary; any non-code input propagates.
module duplex_rail_cell (
    input  logic x0,
    input  logic x1,
    input  logic y0,
    input  logic y1,
    output logic z0,
    output logic z1
);

    assign z0 = (x0 & y0) | (x1 & y1);
    assign z1 = (x0 & y1) | (x1 & y0);

endmodule

// File: rtl/duplex_lane_prep.sv
// Packs both buses into lane vectors, applies the test-mode lane flip to
// the second processor, and inverts its side to form two-rail pairs.
module duplex_lane_prep #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 4,
    localparam int LANES = AW + DW + CW + 1,
    localparam int SELW  = $clog2(LANES)
) (
    input  logic [AW-1:0]   a_addr,
    input  logic [DW-1:0]   a_wdata,
    input  logic [CW-1:0]   a_ctrl,
    input  logic            a_valid,
    input  logic [AW-1:0]   b_addr,
    input  logic [DW-1:0]   b_wdata,
    input  logic [CW-1:0]   b_ctrl,
    input  logic            b_valid,
    input  logic            inject_en,
    input  logic [SELW-1:0] inject_sel,
    output logic [LANES-1:0] rail_t,
    output logic [LANES-1:0] rail_f,
    output logic             active
);

    logic [LANES-1:0] a_lane;
    logic [LANES-1:0] b_lane;
    logic [LANES-1:0] flip;

    assign a_lane = {a_valid, a_ctrl, a_wdata, a_addr};
    assign b_lane = {b_valid, b_ctrl, b_wdata, b_addr};

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            flip[i] = inject_en && (int'(inject_sel) == i);
        end
    end

    assign rail_t = a_lane;
    assign rail_f = ~(b_lane ^ flip);
    assign active = a_valid | b_valid;

endmodule

// File: rtl/duplex_rail_tree.sv
// Balanced tree of two-rail cells; unused leaves are padded with 10,
// which is neutral in the tree.
module duplex_rail_tree #(
    parameter int LANES = 37,
    localparam int LEVELS = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int NP     = 1 << LEVELS
) (
    input  logic [LANES-1:0] rail_t,
    input  logic [LANES-1:0] rail_f,
    output logic [1:0]       rail_out
);

    genvar l, n;
    for (l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int NODES = NP >> l;
        logic [NODES-1:0] r0;
        logic [NODES-1:0] r1;
        if (l == 0) begin : g_leaf
            for (n = 0; n < NODES; n++) begin : g_n
                if (n < LANES) begin : g_real
                    assign r0[n] = rail_t[n];
                    assign r1[n] = rail_f[n];
                end else begin : g_pad
                    assign r0[n] = 1'b1;
                    assign r1[n] = 1'b0;
                end
            end
        end else begin : g_join
            for (n = 0; n < NODES; n++) begin : g_n
                duplex_rail_cell u_cell (
                    .x0 (g_lvl[l-1].r0[2*n]),
                    .x1 (g_lvl[l-1].r1[2*n]),
                    .y0 (g_lvl[l-1].r0[2*n+1]),
                    .y1 (g_lvl[l-1].r1[2*n+1]),
                    .z0 (r0[n]),
                    .z1 (r1[n])
                );
            end
        end
    end

    assign rail_out = {g_lvl[LEVELS].r0[0], g_lvl[LEVELS].r1[0]};

endmodule

// File: rtl/duplex_halt_fsm.sv
// Halt controller: trips on an invalid registered code, pulses the
// memory-system error, holds halt until recovery completes.
module duplex_halt_fsm
    import duplex_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rail_q,
    input  logic       recover_done,
    output logic       halt_req,
    output logic       err_to_mem,
    output logic [1:0] first_code
);

    dx_state_e st_q;
    dx_state_e st_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_n;
        end
    end

    // Transitions
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_RUN:    if (rail_invalid(rail_q)) st_n = ST_ALERT;
            ST_ALERT:  st_n = ST_HALTED;
            ST_HALTED: if (recover_done) st_n = ST_RUN;
            default:   st_n = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        halt_req   = 1'b0;
        err_to_mem = 1'b0;
        unique case (st_q)
            ST_RUN:    ;
            ST_ALERT:  begin halt_req = 1'b1; err_to_mem = 1'b1; end
            ST_HALTED: halt_req = 1'b1;
            default:   ;
        endcase
    end

    // First-error code capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_code <= RAIL_IDLE;
        end else if (st_q == ST_RUN && st_n == ST_ALERT) begin
            first_code <= rail_q;
        end else if (st_q == ST_HALTED && st_n == ST_RUN) begin
            first_code <= RAIL_IDLE;
        end
    end

endmodule

// File: rtl/lockstep_duplex_cmp.sv
module lockstep_duplex_cmp
    import duplex_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [AW-1:0]                   a_addr,
    input  logic [DW-1:0]                   a_wdata,
    input  logic [CW-1:0]                   a_ctrl,
    input  logic                            a_valid,
    input  logic [AW-1:0]                   b_addr,
    input  logic [DW-1:0]                   b_wdata,
    input  logic [CW-1:0]                   b_ctrl,
    input  logic                            b_valid,
    input  logic                            recover_done,
    input  logic                            inject_en,
    input  logic [$clog2(AW+DW+CW+1)-1:0]   inject_sel,
    output logic [1:0]                      chk_rail,
    output logic                            err_to_mem,
    output logic                            halt_req,
    output logic [1:0]                      first_code
);

    localparam int LANES = AW + DW + CW + 1;

    logic [LANES-1:0] rail_t;
    logic [LANES-1:0] rail_f;
    logic             active;
    logic [1:0]       tree_out;
    logic [1:0]       rail_q;

    duplex_lane_prep #(.AW(AW), .DW(DW), .CW(CW)) u_prep (
        .a_addr     (a_addr),
        .a_wdata    (a_wdata),
        .a_ctrl     (a_ctrl),
        .a_valid    (a_valid),
        .b_addr     (b_addr),
        .b_wdata    (b_wdata),
        .b_ctrl     (b_ctrl),
        .b_valid    (b_valid),
        .inject_en  (inject_en),
        .inject_sel (inject_sel),
        .rail_t     (rail_t),
        .rail_f     (rail_f),
        .active     (active)
    );

    duplex_rail_tree #(.LANES(LANES)) u_tree (
        .rail_t   (rail_t),
        .rail_f   (rail_f),
        .rail_out (tree_out)
    );

    // Registered result; no comparison while halted or idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_q <= RAIL_IDLE;
        end else if (active && !halt_req) begin
            rail_q <= tree_out;
        end else begin
            rail_q <= RAIL_IDLE;
        end
    end

    duplex_halt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rail_q       (rail_q),
        .recover_done (recover_done),
        .halt_req     (halt_req),
        .err_to_mem   (err_to_mem),
        .first_code   (first_code)
    );

    assign chk_rail = rail_q;

endmodule

// File: rtl/lockstep_duplex_sva.sv
module lockstep_duplex_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       a_valid,
    input logic       b_valid,
    input logic       recover_done,
    input logic [1:0] chk_rail,
    input logic       err_to_mem,
    input logic       halt_req,
    input logic [1:0] first_code
);

    assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_valid && !b_valid) |=> (chk_rail == 2'b01));

    assert_bad_code_trips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && (chk_rail[1] == chk_rail[0])) |=> err_to_mem);

    assert_alert_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_to_mem |-> halt_req);

    assert_alert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_to_mem |=> !err_to_mem);

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !recover_done) |=> halt_req);

    assert_code_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !recover_done) |=> $stable(first_code));

    assert_code_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (first_code[1] == first_code[0]));

    assert_no_compare_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> (chk_rail == 2'b01));

endmodule

bind lockstep_duplex_cmp lockstep_duplex_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_valid      (a_valid),
    .b_valid      (b_valid),
    .recover_done (recover_done),
    .chk_rail     (chk_rail),
    .err_to_mem   (err_to_mem),
    .halt_req     (halt_req),
    .first_code   (first_code)
);

// File: tb/lockstep_duplex_cmp_test.sv
`timescale 1ns/1ps
module lockstep_duplex_cmp_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [36:0] a_vec = '0;
    logic [36:0] b_vec = '0;
    logic        recover_done = 1'b0;
    logic        inject_en = 1'b0;
    logic [5:0]  inject_sel = '0;
    logic [1:0]  chk_rail;
    logic        err_to_mem;
    logic        halt_req;
    logic [1:0]  first_code;

    int checks = 0;
    int failures = 0;

    // Reference model state: 0 run, 1 alert, 2 halted
    int         m_state = 0;
    logic [1:0] m_rail = 2'b01;
    logic [1:0] m_code = 2'b01;

    always #4 clk = ~clk;

    lockstep_duplex_cmp uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .a_addr       (a_vec[15:0]),
        .a_wdata      (a_vec[31:16]),
        .a_ctrl       (a_vec[35:32]),
        .a_valid      (a_vec[36]),
        .b_addr       (b_vec[15:0]),
        .b_wdata      (b_vec[31:16]),
        .b_ctrl       (b_vec[35:32]),
        .b_valid      (b_vec[36]),
        .recover_done (recover_done),
        .inject_en    (inject_en),
        .inject_sel   (inject_sel),
        .chk_rail     (chk_rail),
        .err_to_mem   (err_to_mem),
        .halt_req     (halt_req),
        .first_code   (first_code)
    );

    function automatic logic [1:0] rail_fn(input logic [36:0] a, input logic [36:0] b,
                                           input logic inj, input logic [5:0] sel,
                                           input logic halted);
        logic [36:0] bb;
        logic [36:0] mm;
        int zeros;
        if (halted || !(a[36] || b[36])) return 2'b01;
        bb = b;
        if (inj && sel < 6'd37) bb[sel] = ~bb[sel];
        mm = a ^ bb;
        if ((mm & ~a) != '0) return 2'b00;
        if (mm != '0) return 2'b11;
        zeros = 0;
        for (int i = 0; i < 37; i++) if (!a[i]) zeros++;
        return zeros[0] ? 2'b01 : 2'b10;
    endfunction

    function automatic string rail_tag(input logic [36:0] a, input logic [36:0] b,
                                       input logic inj, input logic halted);
        if (halted) return "R8";
        if (!(a[36] || b[36])) return "R4";
        if (inj) return "R9";
        if (a != b) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, model the edge, check after it
    task automatic cycle(input logic [36:0] a, input logic [36:0] b, input logic rd,
                         input logic inj, input logic [5:0] sel);
        logic [1:0] nxt;
        string tg;
        @(negedge clk);
        a_vec = a; b_vec = b; recover_done = rd; inject_en = inj; inject_sel = sel;
        @(posedge clk);
        nxt = rail_fn(a, b, inj, sel, m_state != 0);
        tg  = rail_tag(a, b, inj, m_state != 0);
        case (m_state)
            0: if (m_rail[1] == m_rail[0]) begin m_state = 1; m_code = m_rail; end
            1: m_state = 2;
            default: if (rd) begin m_state = 0; m_code = 2'b01; end
        endcase
        m_rail = nxt;
        #2;
        check(tg, "chk_rail", chk_rail, m_rail);
        check("R5", "err_to_mem", {1'b0, err_to_mem}, {1'b0, m_state == 1});
        check("R6", "halt_req", {1'b0, halt_req}, {1'b0, m_state != 0});
        check("R7", "first_code", first_code, m_code);
    endtask

    localparam logic [36:0] ALL1 = {37{1'b1}};

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [36:0] a;
        logic [36:0] b;
        void'($urandom(32'd7741));
        #20;
        // R1 reset state
        check("R1", "chk_rail", chk_rail, 2'b01);
        check("R1", "first_code", first_code, 2'b01);
        check("R1", "halt_req", {1'b0, halt_req}, 2'b00);
        check("R1", "err_to_mem", {1'b0, err_to_mem}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 matches: zero count even, then odd
        cycle(ALL1, ALL1, 1'b0, 1'b0, 6'd0);
        cycle(ALL1 ^ 37'h4, ALL1 ^ 37'h4, 1'b0, 1'b0, 6'd0);
        // R4 idle with differing buses
        cycle(37'h0_1234_5678, 37'h0_0000_0001, 1'b0, 1'b0, 6'd0);
        // R3 mismatch with a 0 on the first side -> 00, then halt path
        cycle(ALL1 ^ 37'h10, ALL1, 1'b0, 1'b0, 6'd0);
        // another mismatch (11) before alert; first code must stay 00 (R7)
        cycle(ALL1, ALL1 ^ 37'h1, 1'b0, 1'b0, 6'd0);
        // ST_ALERT: recover_done ignored (R6)
        cycle(ALL1, ALL1 ^ 37'h2, 1'b1, 1'b0, 6'd0);
        cycle(ALL1, ALL1 ^ 37'h2, 1'b0, 1'b0, 6'd0);
        cycle(ALL1, ALL1, 1'b0, 1'b0, 6'd0);
        // R8 collision: mismatch with recover_done in halted state
        cycle(ALL1 ^ 37'h8, ALL1, 1'b1, 1'b0, 6'd0);
        cycle(ALL1, ALL1, 1'b0, 1'b0, 6'd0);
        cycle(ALL1, ALL1, 1'b0, 1'b0, 6'd0);
        // R9 out-of-range lane has no effect
        cycle(ALL1, ALL1, 1'b0, 1'b1, 6'd40);
        cycle(ALL1, ALL1, 1'b0, 1'b0, 6'd0);
        // R9 inject on valid lane (bit 36), first side 1 -> 11
        cycle(ALL1, ALL1, 1'b0, 1'b1, 6'd36);
        repeat (4) cycle(ALL1, ALL1, 1'b1, 1'b0, 6'd0);
        // R9 inject while idle has no effect
        cycle(37'h0, 37'h0, 1'b0, 1'b1, 6'd3);
        cycle(37'h0, 37'h0, 1'b0, 1'b0, 6'd0);
        // R3 single valid strobe only
        cycle(37'h10_0000_0000, 37'h0, 1'b0, 1'b0, 6'd0);
        repeat (4) cycle(37'h0, 37'h0, 1'b1, 1'b0, 6'd0);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic rd;
            logic inj;
            logic [5:0] sel;
            a = {$urandom, $urandom};
            a[36] = ($urandom % 8) != 0;
            b = a;
            if ($urandom % 12 == 0) b[$urandom % 37] ^= 1'b1;
            rd  = ($urandom % 4) == 0;
            inj = ($urandom % 16) == 0;
            sel = 6'($urandom % 64);
            cycle(a, b, rd, inj, sel);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule